// File: doc/BRIEF.md
# Tuner Synthesizer I2C Write Decoder

This block is a write-only I2C target for the control register set of a frequency synthesizer. It samples the bus clock and data lines into the system clock domain and detects START and STOP conditions. It compares the first byte of each transfer against a fixed device code and two strap pins, and acknowledges every byte of a transfer that matches. It then groups the data bytes into pairs and loads the pairs into the synthesizer settings.

The most significant bit of the first byte in a pair selects the pair's type. A divider pair carries a 15-bit programmable divide ratio. A control pair carries two things:
- a select bit that steers six payload bits into either the test/reference-divider setting or the AGC setting;
- the charge-pump current and five port enables.

A pair only takes effect once its second byte has been acknowledged. A transfer cut short leaves every setting as it was. Traffic for any other device on the bus is ignored.

Top module: `tuner_cfg_i2c`

## Requirements
- R1: The address byte is acknowledged (the block pulls SDA low for the ninth clock) only when bits 7:3 equal 11000, bits 2:1 equal `addr_pins`, and bit 0 (read/write) is 0.
- R2: Every data byte of a matched transfer is acknowledged. `sda_oe` rises on the SCL fall after the eighth bit and drops on the SCL fall after the ninth bit, or earlier on START or STOP.
- R3: After an address that does not match, or that requests a read, the block acknowledges nothing and changes no output until the next START.
- R4: In a pair whose first byte has bit 7 = 0, first-byte bits 6:0 become `div_ratio[14:8]` and the second byte becomes `div_ratio[7:0]`. The ratio is plain binary.
- R5: The outputs of a pair change only after the second byte's acknowledge clock ends. A pair interrupted by STOP or a repeated START is discarded.
- R6: In a pair whose first byte has bit 7 = 1 and bit 6 = 1, first-byte bits 5:3 load `test_bits` and bits 2:0 load `ref_sel`. The AGC outputs keep their values.
- R7: In a pair whose first byte has bit 7 = 1 and bit 6 = 0, bit 5 loads `agc_fast` and bits 4:2 load `agc_top`, and bits 1:0 are ignored. `test_bits` and `ref_sel` keep their values.
- R8: The second byte of a control pair loads `cp_cur` from bits 7:5 and `port_en` from bits 4:0. Reset clears every output to 0, so all ports start off.
- R9: One transfer may carry any number of pairs in any order. Each pair is classified by its own first byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | I2C clock line as seen on the bus |
| sda_i | input | 1 | I2C data line as seen on the bus |
| addr_pins | input | 2 | Strap pins that set the two programmable address bits |
| sda_oe | output | 1 | 1 pulls SDA low (acknowledge) |
| div_ratio | output | 15 | Programmable divide ratio |
| test_bits | output | 3 | Test mode setting |
| ref_sel | output | 3 | Reference divider / step select |
| agc_fast | output | 1 | AGC current and time-constant select |
| agc_top | output | 3 | AGC take-over point |
| cp_cur | output | 3 | Charge-pump current select |
| port_en | output | 5 | Port enables, 1 = on |

## Verification
Checks that hold on every cycle:
- the acknowledge driver only switches on an SCL fall, START or STOP;
- settings move only in the cycle after a completed pair;
- the test/reference and AGC settings never change together;
- reset clears the ports.

Only the bench's transfers can show the rest:
- the address match over all strap, address and direction combinations;
- the bit placement of the divider and control fields;
- that AGC payload bits leave the test setting alone, and the reverse;
- that interrupted pairs and foreign traffic leave the registers untouched.

// File: rtl/tuner_cfg_pkg.sv
package tuner_cfg_pkg;

  localparam int BYTE_W = 8;
  localparam int CTL_W  = 3;
  localparam int PORT_W = 5;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_ADDR,
    RX_ADDR_ACK,
    RX_DATA,
    RX_DATA_ACK,
    RX_IGNORE
  } rx_state_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_q;
  logic              sda_q;
  logic              scl_now;

  // the idle bus level is high on both lines
  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_now   = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_now & ~scl_q;
  assign scl_fall  = ~scl_now & scl_q;
  assign start_det = scl_now & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_now & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_byte_rx.sv
module i2c_byte_rx
  import tuner_cfg_pkg::*;
#(
  parameter logic [4:0] DEV_CODE = 5'b11000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [1:0]        addr_pins,
  output logic              sda_oe,
  output logic              byte_valid,
  output logic [BYTE_W-1:0] byte_data
);

  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  rx_state_t         state;
  logic [BYTE_W-1:0] shreg;
  logic [CNT_W-1:0]  cnt;
  logic              addr_hit;

  assign addr_hit = (shreg == {DEV_CODE, addr_pins, 1'b0});

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= RX_IDLE;
      shreg      <= '0;
      cnt        <= '0;
      sda_oe     <= 1'b0;
      byte_valid <= 1'b0;
      byte_data  <= '0;
    end else begin
      byte_valid <= 1'b0;
      if (start_det) begin
        state  <= RX_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        state  <= RX_IDLE;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          RX_ADDR, RX_DATA: begin
            if (scl_rise && cnt != FULL) begin
              shreg <= {shreg[BYTE_W-2:0], sda_s};
              cnt   <= cnt + 1'b1;
            end else if (scl_fall && cnt == FULL) begin
              if (state == RX_DATA) begin
                sda_oe    <= 1'b1;
                byte_data <= shreg;
                state     <= RX_DATA_ACK;
              end else if (addr_hit) begin
                sda_oe <= 1'b1;
                state  <= RX_ADDR_ACK;
              end else begin
                state <= RX_IGNORE;
              end
            end
          end
          RX_ADDR_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              cnt    <= '0;
              state  <= RX_DATA;
            end
          end
          RX_DATA_ACK: begin
            if (scl_fall) begin
              sda_oe     <= 1'b0;
              cnt        <= '0;
              byte_valid <= 1'b1;
              state      <= RX_DATA;
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/tuner_reg_bank.sv
module tuner_reg_bank
  import tuner_cfg_pkg::*;
#(
  parameter int DIV_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_reset,
  input  logic              byte_valid,
  input  logic [BYTE_W-1:0] byte_data,
  output logic [DIV_W-1:0]  div_ratio,
  output logic [CTL_W-1:0]  test_bits,
  output logic [CTL_W-1:0]  ref_sel,
  output logic              agc_fast,
  output logic [CTL_W-1:0]  agc_top,
  output logic [CTL_W-1:0]  cp_cur,
  output logic [PORT_W-1:0] port_en
);

  localparam int HI_W = DIV_W - BYTE_W;

  logic              pair_open;
  logic [BYTE_W-1:0] head_q;
  logic              is_ctrl;
  logic              sel_test;

  assign is_ctrl  = head_q[BYTE_W-1];
  assign sel_test = head_q[BYTE_W-2];

  always_ff @(posedge clk) begin
    if (rst) begin
      pair_open <= 1'b0;
      head_q    <= '0;
      div_ratio <= '0;
      test_bits <= '0;
      ref_sel   <= '0;
      agc_fast  <= 1'b0;
      agc_top   <= '0;
      cp_cur    <= '0;
      port_en   <= '0;
    end else if (frame_reset) begin
      pair_open <= 1'b0;
    end else if (byte_valid) begin
      if (!pair_open) begin
        head_q    <= byte_data;
        pair_open <= 1'b1;
      end else begin
        pair_open <= 1'b0;
        if (!is_ctrl) begin
          div_ratio <= {head_q[HI_W-1:0], byte_data};
        end else begin
          cp_cur  <= byte_data[BYTE_W-1 -: CTL_W];
          port_en <= byte_data[PORT_W-1:0];
          if (sel_test) begin
            test_bits <= head_q[5:3];
            ref_sel   <= head_q[2:0];
          end else begin
            agc_fast <= head_q[5];
            agc_top  <= head_q[4:2];
          end
        end
      end
    end
  end

endmodule

// File: rtl/tuner_cfg_i2c.sv
module tuner_cfg_i2c
  import tuner_cfg_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter int         DIV_W       = 15,
  parameter logic [4:0] DEV_CODE    = 5'b11000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [1:0]        addr_pins,
  output logic              sda_oe,
  output logic [DIV_W-1:0]  div_ratio,
  output logic [CTL_W-1:0]  test_bits,
  output logic [CTL_W-1:0]  ref_sel,
  output logic              agc_fast,
  output logic [CTL_W-1:0]  agc_top,
  output logic [CTL_W-1:0]  cp_cur,
  output logic [PORT_W-1:0] port_en
);

  logic              sda_s;
  logic              scl_rise;
  logic              scl_fall;
  logic              start_det;
  logic              stop_det;
  logic              byte_valid;
  logic [BYTE_W-1:0] byte_data;
  logic              frame_reset;

  assign frame_reset = start_det | stop_det;

  i2c_line_sync #(
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk      (clk),
    .rst      (rst),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  i2c_byte_rx #(
    .DEV_CODE(DEV_CODE)
  ) u_rx (
    .clk       (clk),
    .rst       (rst),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .addr_pins (addr_pins),
    .sda_oe    (sda_oe),
    .byte_valid(byte_valid),
    .byte_data (byte_data)
  );

  tuner_reg_bank #(
    .DIV_W(DIV_W)
  ) u_regs (
    .clk        (clk),
    .rst        (rst),
    .frame_reset(frame_reset),
    .byte_valid (byte_valid),
    .byte_data  (byte_data),
    .div_ratio  (div_ratio),
    .test_bits  (test_bits),
    .ref_sel    (ref_sel),
    .agc_fast   (agc_fast),
    .agc_top    (agc_top),
    .cp_cur     (cp_cur),
    .port_en    (port_en)
  );

endmodule

// File: rtl/tuner_cfg_checker.sv
module tuner_cfg_checker #(
  parameter int DIV_W = 15
) (
  input logic             clk,
  input logic             rst,
  input logic             sda_oe,
  input logic             scl_fall,
  input logic             start_det,
  input logic             stop_det,
  input logic             byte_valid,
  input logic [DIV_W-1:0] div_ratio,
  input logic [2:0]       test_bits,
  input logic [2:0]       ref_sel,
  input logic             agc_fast,
  input logic [2:0]       agc_top,
  input logic [2:0]       cp_cur,
  input logic [4:0]       port_en
);

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (port_en == '0 && div_ratio == '0 && !sda_oe)); // R8

  AST_ACK_RISES_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> $past(scl_fall)); // R2

  AST_ACK_DROPS_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
    $fell(sda_oe) |-> $past(scl_fall || start_det || stop_det)); // R2

  AST_STOP_RELEASES_SDA: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_oe); // R3

  AST_DIV_ONLY_ON_PAIR: assert property (@(posedge clk) disable iff (rst)
    !$stable(div_ratio) |-> $past(byte_valid)); // R5

  AST_CTRL_ONLY_ON_PAIR: assert property (@(posedge clk) disable iff (rst)
    !$stable({test_bits, ref_sel, agc_fast, agc_top, cp_cur, port_en})
      |-> $past(byte_valid)); // R6

  AST_TEST_AGC_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(!$stable({test_bits, ref_sel}) && !$stable({agc_fast, agc_top}))); // R7

endmodule

bind tuner_cfg_i2c tuner_cfg_checker #(.DIV_W(DIV_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .sda_oe    (sda_oe),
  .scl_fall  (scl_fall),
  .start_det (start_det),
  .stop_det  (stop_det),
  .byte_valid(byte_valid),
  .div_ratio (div_ratio),
  .test_bits (test_bits),
  .ref_sel   (ref_sel),
  .agc_fast  (agc_fast),
  .agc_top   (agc_top),
  .cp_cur    (cp_cur),
  .port_en   (port_en)
);

// File: tb/tuner_cfg_i2c_test.sv
module tuner_cfg_i2c_test;

  localparam int H  = 10;
  localparam int HH = H / 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bench_scl = 1'b1;
  logic bench_sda = 1'b1;
  logic [1:0] addr_pins = 2'b10;
  logic sda_oe;
  logic [14:0] div_ratio;
  logic [2:0] test_bits, ref_sel, agc_top, cp_cur;
  logic agc_fast;
  logic [4:0] port_en;
  wire sda_line = bench_sda & ~sda_oe;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  logic [14:0] e_div = '0;
  logic [2:0]  e_test = '0, e_ref = '0, e_agct = '0, e_cp = '0;
  logic        e_agcf = 1'b0;
  logic [4:0]  e_port = '0;
  bit          m_open = 0;
  logic [7:0]  m_head = '0;

  always #5 clk = ~clk;

  tuner_cfg_i2c uut (
    .clk(clk), .rst(rst), .scl_i(bench_scl), .sda_i(sda_line),
    .addr_pins(addr_pins), .sda_oe(sda_oe), .div_ratio(div_ratio),
    .test_bits(test_bits), .ref_sel(ref_sel), .agc_fast(agc_fast),
    .agc_top(agc_top), .cp_cur(cp_cur), .port_en(port_en)
  );

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk({tag, " R4 div"}, div_ratio, e_div);
    chk({tag, " R6 test"}, test_bits, e_test);
    chk({tag, " R6 ref"}, ref_sel, e_ref);
    chk({tag, " R7 agc_fast"}, agc_fast, e_agcf);
    chk({tag, " R7 agc_top"}, agc_top, e_agct);
    chk({tag, " R8 cp"}, cp_cur, e_cp);
    chk({tag, " R8 port"}, port_en, e_port);
  endtask

  // expected-value model of a completed byte, built from R4 and R6 to R9
  task automatic model_byte(input logic [7:0] b);
    if (!m_open) begin
      m_head = b;
      m_open = 1;
    end else begin
      m_open = 0;
      if (m_head[7] == 1'b0) begin
        e_div = {m_head[6:0], b};
      end else begin
        e_cp   = b[7:5];
        e_port = b[4:0];
        if (m_head[6]) begin
          e_test = m_head[5:3];
          e_ref  = m_head[2:0];
        end else begin
          e_agcf = m_head[5];
          e_agct = m_head[4:2];
        end
      end
    end
  endtask

  task automatic bus_start();
    bench_sda = 1'b1; wclk(HH);
    bench_scl = 1'b1; wclk(HH);
    bench_sda = 1'b0; wclk(HH);
    bench_scl = 1'b0; wclk(HH);
    m_open = 0;
  endtask

  task automatic bus_stop();
    bench_sda = 1'b0; wclk(HH);
    bench_scl = 1'b1; wclk(HH);
    bench_sda = 1'b1; wclk(H);
    m_open = 0;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      bench_sda = b[i]; wclk(HH);
      bench_scl = 1'b1; wclk(H);
      bench_scl = 1'b0; wclk(HH);
    end
    bench_sda = 1'b1; wclk(HH);
    bench_scl = 1'b1; wclk(HH);
    ack = sda_oe;
    wclk(HH);
    bench_scl = 1'b0; wclk(HH);
  endtask

  task automatic open_own();
    logic a;
    bus_start();
    send_byte({5'b11000, addr_pins, 1'b0}, a);
    chk("R1 own address ack", a, 1);
  endtask

  task automatic data(input logic [7:0] b);
    logic a;
    send_byte(b, a);
    chk("R2 data ack", a, 1);
    model_byte(b);
  endtask

  task automatic pair_frame(input logic [7:0] b1, input logic [7:0] b2, input string tag);
    open_own();
    data(b1);
    data(b2);
    bus_stop();
    check_all(tag);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      miscompares++;
      vectors++;
      $display("FAIL R5 watchdog act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic a;
    wclk(4);
    rst = 1'b0;
    wclk(4);
    // R8: reset state
    check_all("reset");
    chk("R8 sda_oe after reset", sda_oe, 0);

    // R1: full sweep of strap pins, programmable bits and direction bit
    for (int p = 0; p < 4; p++) begin
      addr_pins = p[1:0];
      for (int ma = 0; ma < 4; ma++) begin
        for (int rw = 0; rw < 2; rw++) begin
          bus_start();
          send_byte({5'b11000, ma[1:0], rw[0]}, a);
          chk("R1 address sweep", a, (ma == p && rw == 0) ? 1 : 0);
          bus_stop();
        end
      end
    end
    // R1: a single wrong bit in the fixed code is refused
    addr_pins = 2'b01;
    for (int k = 0; k < 5; k++) begin
      logic [4:0] code;
      code = 5'b11000 ^ (5'b00001 << k);
      bus_start();
      send_byte({code, 2'b01, 1'b0}, a);
      chk("R1 wrong fixed code", a, 0);
      bus_stop();
    end

    // R3: foreign address, then a whole divider pair, is ignored
    bus_start();
    send_byte({5'b11000, 2'b10, 1'b0}, a);
    chk("R3 foreign address nack", a, 0);
    send_byte(8'h12, a); chk("R3 no ack after mismatch", a, 0);
    send_byte(8'h34, a); chk("R3 no ack after mismatch", a, 0);
    bus_stop();
    check_all("R3 foreign");
    // R3: read request to own address is ignored
    bus_start();
    send_byte({5'b11000, addr_pins, 1'b1}, a);
    chk("R3 read nack", a, 0);
    send_byte(8'hC5, a); chk("R3 no ack after read", a, 0);
    send_byte(8'hFF, a); chk("R3 no ack after read", a, 0);
    bus_stop();
    check_all("R3 read");

    // R4: walking ones and patterns over the divider
    for (int k = 0; k < 15; k++) begin
      logic [14:0] n;
      n = 15'(1) << k;
      pair_frame({1'b0, n[14:8]}, n[7:0], "R4 walk");
      chk("R4 value", div_ratio, 1 << k);
    end
    pair_frame(8'h7F, 8'hFF, "R4 max");
    chk("R4 max value", div_ratio, 32767);
    pair_frame(8'h5A, 8'h3C, "R4 pattern");

    // R6: test/reference payloads
    for (int p = 0; p < 64; p += 3) begin
      logic [7:0] b2;
      b2 = 8'((p * 37 + 11) % 256);
      pair_frame({2'b11, p[5:0]}, b2, "R6 test mode");
    end
    // R7: AGC payloads, test/ref must stay put
    for (int p = 0; p < 64; p += 3) begin
      logic [7:0] b2;
      b2 = 8'((p * 53 + 7) % 256);
      pair_frame({2'b10, p[5:0]}, b2, "R7 agc mode");
    end
    // R8: all-ones and all-zeros port byte
    pair_frame(8'hC0, 8'hFF, "R8 ports on");
    chk("R8 port_en all on", port_en, 5'h1F);
    pair_frame(8'hC0, 8'h00, "R8 ports off");

    // R5: pair cut by STOP
    open_own();
    data(8'h2B);
    bus_stop();
    check_all("R5 cut by stop");
    // R5: pair cut by repeated START, then a full control pair
    open_own();
    data(8'h11);
    open_own();
    data(8'hE5);
    data(8'hA3);
    bus_stop();
    check_all("R5 repeated start");

    // R9: several pairs in one transfer, mixed order
    open_own();
    data(8'hDB); data(8'h6E);
    data(8'h33); data(8'h99);
    data(8'hB7); data(8'h15);
    data(8'h01); data(8'h80);
    bus_stop();
    check_all("R9 multi pair");
    chk("R9 final divider", div_ratio, 15'h0180);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule